// File: doc/BRIEF.md
# Scan pattern sequencer

This block drives the scan test of a logic region whose flip-flops sit behind scan multiplexers. It takes one pattern word at a time from a pattern store over a valid/ready fetch port. It shifts the stimulus into every scan chain while scan enable is high. It then drops scan enable, drives the primary-input stimulus and checks the primary outputs. Next it fires a single capture-enable cycle. Finally it shifts the captured response back out while the next pattern goes in.

All shift phases last as many cycles as the longest chain. A shorter chain receives filler bits first, so that every chain holds its real stimulus when the shift ends. Stimulus bits marked as don't-care, and all filler bits, come from a 16-bit pseudo-random generator. Unloaded bits and primary outputs are compared only where their mask bit is set. Any mismatch sets a sticky fail flag. A done flag rises once the last response has been unloaded.

The fetch port follows valid/ready rules. `pat_rd_valid` rises with `pat_rd_addr`, and both stay unchanged until the store raises `pat_rd_ready`. `pat_rd_data` is taken in the cycle where both are high. The store may hold ready low for any number of cycles. During that time the sequencer stays parked with scan enable and capture enable low. All other pins are plain level signals.

Top module: `scan_pattern_sequencer`

## Requirements
- R1: While reset is released and before the first clock edge, `pat_rd_valid` is 1 with address 0, and `scan_en`, `cap_en`, `done` and `fail` are all 0.
- R2: During a fetch, `pat_rd_valid` stays high and `pat_rd_addr` stays stable until `pat_rd_ready` is seen. The word is taken in that cycle and `scan_en` rises in the next cycle. With L the longest chain and C chains, the word is laid out from bit 0 upward as follows: stimulus (C·L bits), care mask (C·L), expected unload (C·L), unload mask (C·L), primary-input stimulus, expected primary outputs, output mask. In each C·L field, chain c position k sits at bit c·L+k.
- R3: Every shift phase keeps `scan_en` high for exactly L consecutive cycles, whatever the individual chain lengths.
- R4: In shift cycle j (counted from 0) of a load, chain c drives its stimulus bit j. This holds only when j ≥ L − len(c) and the care bit j of that chain is 1.
- R5: Otherwise the chain drives bit (c mod 16) of a 16-bit LFSR. The LFSR uses the polynomial x^16+x^14+x^13+x^11+1, shifts left with the feedback entering bit 0, and starts from the seed parameter. It advances once per shift cycle. Filler from the LFSR is also driven throughout the final unload.
- R6: After each load shift, one apply cycle follows with `scan_en` low and the pattern's primary-input stimulus on `pi_drive`. Then one cycle with `cap_en` high follows. `scan_en` is low both in the capture cycle and in the cycle before it.
- R7: In the apply cycle, `po_sample` is compared with the expected outputs only at bit positions whose output mask bit is 1.
- R8: The shift after capture of pattern N loads pattern N+1 and unloads pattern N in the same cycles. The chain c bit on `scan_out` in shift cycle k is compared with expected bit k only when k < len(c) and the unload mask bit is 1.
- R9: `fail` goes to 1 in the cycle after any compared mismatch and stays at 1 until reset.
- R10: After the final capture, one extra shift of L cycles unloads the last pattern. `done` rises in the next cycle and stays high, with `scan_en` and `pat_rd_valid` low.
- R11: While a fetch waits for `pat_rd_ready`, no shift or capture takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pat_rd_valid | output | 1 | Fetch request valid |
| pat_rd_addr | output | ADDR_W | Index of the pattern requested |
| pat_rd_ready | input | 1 | Pattern store presents the word |
| pat_rd_data | input | PAT_W | Pattern word (layout in R2) |
| scan_en | output | 1 | Scan multiplexer select, high = shift |
| scan_in | output | NUM_CHAINS | Serial stimulus, one bit per chain |
| scan_out | input | NUM_CHAINS | Serial response, one bit per chain |
| cap_en | output | 1 | One-cycle capture clock enable |
| pi_drive | output | PI_W | Primary-input stimulus |
| po_sample | input | PO_W | Primary outputs of the logic under test |
| fail | output | 1 | Sticky mismatch flag |
| done | output | 1 | All patterns applied and unloaded |

## Verification
The bench builds the sequencer with three chains of lengths 6, 3 and 5, three patterns, and 4-bit primary inputs and outputs. With these values the padding amounts are zero, one and three. It also creates unload positions past a short chain's end that carry a set mask bit, two fully overlapped load/unload shifts, and the final unload-only shift. A behavioural scan-chain model that inverts its contents on capture produces real responses. The runs use fetch back-pressure of zero and two cycles, together with deliberately corrupted masked and unmasked expectations.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [2:0] {
    PH_FETCH,
    PH_SHIFT,
    PH_APPLY,
    PH_CAPTURE,
    PH_DONE
  } phase_e;

  // Longest chain among n chains whose 8-bit lengths are packed in lens.
  function automatic int longest(input int n, input logic [255:0] lens);
    int m = 0;
    for (int i = 0; i < n; i++) begin
      if (int'(lens[i*8 +: 8]) > m) m = int'(lens[i*8 +: 8]);
    end
    return m;
  endfunction

  // Left-shifting 16-bit maximal-length step, taps 16/14/13/11.
  function automatic logic [15:0] fill_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/sps_fill_lfsr.sv
module sps_fill_lfsr #(
  parameter logic [15:0] SEED  = 16'hACE1,
  parameter int          OUT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [OUT_W-1:0] taps
);

  logic [15:0] state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= sps_pkg::fill_next(state);
  end

  for (genvar c = 0; c < OUT_W; c++) begin : g_tap
    assign taps[c] = state[c % 16];
  end

  assert_fill_advances_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> state != $past(state));

endmodule

// File: rtl/sps_chain_drive.sv
module sps_chain_drive #(
  parameter int                      NUM_CHAINS = 2,
  parameter int                      MAX_LEN    = 6,
  parameter logic [NUM_CHAINS*8-1:0] CHAIN_LENS = {8'd4, 8'd6},
  parameter int                      CNT_W      = 3
) (
  input  logic                          loading,
  input  logic [CNT_W-1:0]              cnt,
  input  logic [NUM_CHAINS*MAX_LEN-1:0] stim,
  input  logic [NUM_CHAINS*MAX_LEN-1:0] care,
  input  logic [NUM_CHAINS-1:0]         fill,
  output logic [NUM_CHAINS-1:0]         si
);

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    localparam int LEN = int'(CHAIN_LENS[c*8 +: 8]);
    localparam int PAD = MAX_LEN - LEN;
    logic [MAX_LEN-1:0] st;
    logic [MAX_LEN-1:0] ca;
    logic               use_pat;
    assign st      = stim[c*MAX_LEN +: MAX_LEN];
    assign ca      = care[c*MAX_LEN +: MAX_LEN];
    assign use_pat = loading && (int'(cnt) >= PAD) && ca[cnt];
    assign si[c]   = use_pat ? st[cnt] : fill[c];
  end

endmodule

// File: rtl/sps_response_check.sv
module sps_response_check #(
  parameter int                      NUM_CHAINS = 2,
  parameter int                      MAX_LEN    = 6,
  parameter logic [NUM_CHAINS*8-1:0] CHAIN_LENS = {8'd4, 8'd6},
  parameter int                      CNT_W      = 3,
  parameter int                      PO_W       = 4
) (
  input  logic                          unl_active,
  input  logic                          apply_active,
  input  logic [CNT_W-1:0]              cnt,
  input  logic [NUM_CHAINS-1:0]         so,
  input  logic [NUM_CHAINS*MAX_LEN-1:0] exp_bits,
  input  logic [NUM_CHAINS*MAX_LEN-1:0] exp_mask,
  input  logic [PO_W-1:0]               po_in,
  input  logic [PO_W-1:0]               po_exp,
  input  logic [PO_W-1:0]               po_mask,
  output logic                          mismatch
);

  logic [NUM_CHAINS-1:0] chain_miss;

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    localparam int LEN = int'(CHAIN_LENS[c*8 +: 8]);
    logic [MAX_LEN-1:0] ex;
    logic [MAX_LEN-1:0] mk;
    assign ex = exp_bits[c*MAX_LEN +: MAX_LEN];
    assign mk = exp_mask[c*MAX_LEN +: MAX_LEN];
    assign chain_miss[c] = unl_active && (int'(cnt) < LEN) && mk[cnt] && (so[c] != ex[cnt]);
  end

  assign mismatch = (|chain_miss) || (apply_active && (|((po_in ^ po_exp) & po_mask)));

endmodule

// File: rtl/scan_pattern_sequencer.sv
module scan_pattern_sequencer
  import sps_pkg::*;
#(
  parameter int                      NUM_CHAINS   = 2,
  parameter logic [NUM_CHAINS*8-1:0] CHAIN_LENS   = {8'd4, 8'd6},
  parameter int                      NUM_PATTERNS = 3,
  parameter int                      PI_W         = 4,
  parameter int                      PO_W         = 4,
  parameter logic [15:0]             FILL_SEED    = 16'hACE1,
  localparam int MAX_LEN = sps_pkg::longest(NUM_CHAINS, 256'(CHAIN_LENS)),
  localparam int BITS    = NUM_CHAINS * MAX_LEN,
  localparam int PAT_W   = 4 * BITS + PI_W + 2 * PO_W,
  localparam int ADDR_W  = (NUM_PATTERNS > 1) ? $clog2(NUM_PATTERNS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic                  pat_rd_valid,
  output logic [ADDR_W-1:0]     pat_rd_addr,
  input  logic                  pat_rd_ready,
  input  logic [PAT_W-1:0]      pat_rd_data,
  output logic                  scan_en,
  output logic [NUM_CHAINS-1:0] scan_in,
  input  logic [NUM_CHAINS-1:0] scan_out,
  output logic                  cap_en,
  output logic [PI_W-1:0]       pi_drive,
  input  logic [PO_W-1:0]       po_sample,
  output logic                  fail,
  output logic                  done
);

  localparam int CNT_W    = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam int OFF_CARE = BITS;
  localparam int OFF_EXP  = 2 * BITS;
  localparam int OFF_MASK = 3 * BITS;
  localparam int OFF_PI   = 4 * BITS;
  localparam int OFF_POE  = OFF_PI + PI_W;
  localparam int OFF_POM  = OFF_POE + PO_W;

  phase_e                phase;
  logic [CNT_W-1:0]      cnt;
  logic [ADDR_W-1:0]     pat_idx;
  logic                  loading;
  logic                  unloading;
  logic [PAT_W-1:0]      pat_q;
  logic [BITS-1:0]       unl_exp;
  logic [BITS-1:0]       unl_mask;
  logic                  fail_q;
  logic                  mismatch;
  logic [NUM_CHAINS-1:0] fill_bits;

  assign pat_rd_valid = (phase == PH_FETCH);
  assign pat_rd_addr  = pat_idx;
  assign scan_en      = (phase == PH_SHIFT);
  assign cap_en       = (phase == PH_CAPTURE);
  assign done         = (phase == PH_DONE);
  assign pi_drive     = pat_q[OFF_PI +: PI_W];
  assign fail         = fail_q;

  sps_fill_lfsr #(
    .SEED (FILL_SEED),
    .OUT_W(NUM_CHAINS)
  ) i_fill (
    .clk  (clk),
    .rst_n(rst_n),
    .step (scan_en),
    .taps (fill_bits)
  );

  sps_chain_drive #(
    .NUM_CHAINS(NUM_CHAINS),
    .MAX_LEN   (MAX_LEN),
    .CHAIN_LENS(CHAIN_LENS),
    .CNT_W     (CNT_W)
  ) i_drive (
    .loading(loading),
    .cnt    (cnt),
    .stim   (pat_q[0 +: BITS]),
    .care   (pat_q[OFF_CARE +: BITS]),
    .fill   (fill_bits),
    .si     (scan_in)
  );

  sps_response_check #(
    .NUM_CHAINS(NUM_CHAINS),
    .MAX_LEN   (MAX_LEN),
    .CHAIN_LENS(CHAIN_LENS),
    .CNT_W     (CNT_W),
    .PO_W      (PO_W)
  ) i_check (
    .unl_active  (scan_en && unloading),
    .apply_active(phase == PH_APPLY),
    .cnt         (cnt),
    .so          (scan_out),
    .exp_bits    (unl_exp),
    .exp_mask    (unl_mask),
    .po_in       (po_sample),
    .po_exp      (pat_q[OFF_POE +: PO_W]),
    .po_mask     (pat_q[OFF_POM +: PO_W]),
    .mismatch    (mismatch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_FETCH;
      cnt       <= '0;
      pat_idx   <= '0;
      loading   <= 1'b0;
      unloading <= 1'b0;
      pat_q     <= '0;
      unl_exp   <= '0;
      unl_mask  <= '0;
      fail_q    <= 1'b0;
    end else begin
      case (phase)
        PH_FETCH: begin
          if (pat_rd_ready) begin
            pat_q   <= pat_rd_data;
            loading <= 1'b1;
            cnt     <= '0;
            phase   <= PH_SHIFT;
          end
        end
        PH_SHIFT: begin
          if (cnt == CNT_W'(MAX_LEN - 1)) begin
            unloading <= 1'b0;
            phase     <= loading ? PH_APPLY : PH_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_APPLY: phase <= PH_CAPTURE;
        PH_CAPTURE: begin
          unl_exp   <= pat_q[OFF_EXP +: BITS];
          unl_mask  <= pat_q[OFF_MASK +: BITS];
          unloading <= 1'b1;
          loading   <= 1'b0;
          cnt       <= '0;
          if (pat_idx == ADDR_W'(NUM_PATTERNS - 1)) begin
            phase <= PH_SHIFT;
          end else begin
            pat_idx <= pat_idx + 1'b1;
            phase   <= PH_FETCH;
          end
        end
        default: ;
      endcase
      if (mismatch) fail_q <= 1'b1;
    end
  end

  // Run-length counter of scan_en, used only by the shift-length check.
  logic [CNT_W:0] se_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       se_run <= '0;
    else if (scan_en) se_run <= se_run + 1'b1;
    else              se_run <= '0;
  end

  assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pat_rd_valid && !pat_rd_ready |=> pat_rd_valid && $stable(pat_rd_addr));

  assert_shift_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_en) |-> se_run == (CNT_W+1)'(MAX_LEN));

  assert_capture_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> !scan_en && !$past(scan_en));

  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail);

  assert_done_final_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !scan_en && !pat_rd_valid);

  assert_stall_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pat_rd_valid |-> !scan_en && !cap_en);

endmodule

// File: tb/test_scan_pattern_sequencer.sv
module test_scan_pattern_sequencer;

  localparam int              CLK_PERIOD = 10;
  localparam int              NC         = 3;
  localparam logic [NC*8-1:0] LENS       = {8'd5, 8'd3, 8'd6};
  localparam int              ML         = 6;
  localparam int              NPAT       = 3;
  localparam int              PIW        = 4;
  localparam int              POW        = 4;
  localparam logic [15:0]     SEED       = 16'h1D0F;
  localparam int              BITS       = NC * ML;
  localparam int              PAT_W      = 4 * BITS + PIW + 2 * POW;
  localparam int              AW         = 2;
  localparam logic [POW-1:0]  PO_XOR     = 4'hA;
  localparam int              RUN_LIMIT  = 2000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pat_rd_valid;
  logic [AW-1:0]    pat_rd_addr;
  logic             pat_rd_ready = 1'b0;
  logic [PAT_W-1:0] pat_rd_data;
  logic             scan_en;
  logic [NC-1:0]    scan_in;
  logic [NC-1:0]    so_bits;
  logic             cap_en;
  logic [PIW-1:0]   pi_drive;
  logic [POW-1:0]   po_sample;
  logic             fail;
  logic             done;

  logic [PAT_W-1:0] mem [NPAT];
  logic [ML-1:0]    chain [NC];

  int n_chk  = 0;
  int n_fail = 0;
  int wait_ctr = 0;
  bit finished = 0;

  // reference model state
  int          m_ph, m_cnt, m_idx, m_cur, m_prev;
  bit          m_load, m_unl, m_fail;
  logic [15:0] m_lfsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_pattern_sequencer #(
    .NUM_CHAINS  (NC),
    .CHAIN_LENS  (LENS),
    .NUM_PATTERNS(NPAT),
    .PI_W        (PIW),
    .PO_W        (POW),
    .FILL_SEED   (SEED)
  ) i_scan_pattern_sequencer (
    .clk         (clk),
    .rst_n       (rst_n),
    .pat_rd_valid(pat_rd_valid),
    .pat_rd_addr (pat_rd_addr),
    .pat_rd_ready(pat_rd_ready),
    .pat_rd_data (pat_rd_data),
    .scan_en     (scan_en),
    .scan_in     (scan_in),
    .scan_out    (so_bits),
    .cap_en      (cap_en),
    .pi_drive    (pi_drive),
    .po_sample   (po_sample),
    .fail        (fail),
    .done        (done)
  );

  function automatic int clen(input int c);
    return int'(LENS[c*8 +: 8]);
  endfunction

  assign pat_rd_data = mem[pat_rd_addr];
  assign po_sample   = pi_drive ^ PO_XOR;

  always_comb begin
    for (int c = 0; c < NC; c++) so_bits[c] = chain[c][clen(c)-1];
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic build(input logic [31:0] seedv, input int mode);
    logic [31:0] r;
    r = seedv;
    for (int p = 0; p < NPAT; p++) begin
      logic [PAT_W-1:0] w;
      w = '0;
      for (int c = 0; c < NC; c++) begin
        for (int j = 0; j < ML; j++) begin
          r = r * 32'd1103515245 + 32'd12345;
          w[c*ML+j]      = r[16];
          w[BITS+c*ML+j] = (r[18:17] != 2'b00);
        end
      end
      for (int c = 0; c < NC; c++) begin
        for (int k = 0; k < ML; k++) begin
          r = r * 32'd1103515245 + 32'd12345;
          if (k < clen(c)) begin
            int j;
            j = ML - clen(c) + k;
            w[2*BITS+c*ML+k] = ~w[c*ML+j];
            w[3*BITS+c*ML+k] = w[BITS+c*ML+j];
          end else begin
            w[2*BITS+c*ML+k] = r[19];
            w[3*BITS+c*ML+k] = 1'b1;   // beyond chain end: must be ignored
          end
        end
      end
      r = r * 32'd1103515245 + 32'd12345;
      w[4*BITS +: PIW]           = r[23:20];
      w[4*BITS+PIW +: POW]       = r[23:20] ^ PO_XOR;
      w[4*BITS+PIW+POW +: POW]   = 4'b1011;
      mem[p] = w;
    end
    if (mode == 1) begin
      // masked-off unload bit and masked-off output bit both wrong
      mem[1][3*BITS+0*ML+0] = 1'b0;
      mem[1][2*BITS+0*ML+0] = ~mem[1][2*BITS+0*ML+0];
      mem[2][4*BITS+PIW+2]  = ~mem[2][4*BITS+PIW+2];
    end else if (mode == 2) begin
      // unmasked unload bit of chain 2, position 1, expected value wrong
      mem[1][BITS+2*ML+(ML-clen(2)+1)] = 1'b1;
      mem[1][3*BITS+2*ML+1]            = 1'b1;
      mem[1][2*BITS+2*ML+1]            = mem[1][2*ML+(ML-clen(2)+1)];
    end else if (mode == 3) begin
      mem[2][4*BITS+PIW+0] = ~mem[2][4*BITS+PIW+0];
    end
  endtask

  task automatic drive_ready(input int delay);
    if (pat_rd_valid) begin
      if (wait_ctr >= delay) pat_rd_ready = 1'b1;
      else begin
        pat_rd_ready = 1'b0;
        wait_ctr++;
      end
    end else begin
      pat_rd_ready = 1'b0;
      wait_ctr = 0;
    end
  endtask

  task automatic run_case(input int mode, input int delay, input bit exp_fail, input string tag);
    int  cyc;
    int  done_cycles;
    bit  s_se, s_cap;
    logic [NC-1:0] s_si;
    rst_n = 1'b0;
    pat_rd_ready = 1'b0;
    wait_ctr = 0;
    build(32'h5EED0000 + 32'(mode), mode);
    for (int c = 0; c < NC; c++) chain[c] = '0;
    m_ph = 0; m_cnt = 0; m_idx = 0; m_cur = 0; m_prev = 0;
    m_load = 0; m_unl = 0; m_fail = 0; m_lfsr = SEED;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    drive_ready(delay);
    cyc = 0;
    done_cycles = 0;
    while (done_cycles < 3 && cyc < RUN_LIMIT) begin
      @(negedge clk);
      if (cyc == 0) begin
        check("R1 valid after reset", pat_rd_valid, 1'b1);
        check("R1 addr after reset", pat_rd_addr, 0);
        check("R1 idle outputs", {scan_en, cap_en, done, fail}, 4'b0000);
      end
      check("R2 fetch valid", pat_rd_valid, m_ph == 0);
      if (m_ph == 0) check("R2 fetch addr", pat_rd_addr, m_idx);
      if (m_ph == 0 && !pat_rd_ready) check("R11 stall quiet", {scan_en, cap_en}, 2'b00);
      check("R3 scan_en", scan_en, m_ph == 1);
      check("R6 cap_en", cap_en, m_ph == 3);
      check("R10 done", done, m_ph == 4);
      check("R9 fail", fail, m_fail);
      if (m_ph == 1) begin
        for (int c = 0; c < NC; c++) begin
          bit from_pat;
          from_pat = m_load && (m_cnt >= ML - clen(c)) && mem[m_cur][BITS+c*ML+m_cnt];
          if (from_pat) check("R4 load bit", scan_in[c], mem[m_cur][c*ML+m_cnt]);
          else          check("R5 fill bit", scan_in[c], m_lfsr[c % 16]);
        end
      end
      if (m_ph == 2) check("R6 pi stimulus", pi_drive, mem[m_cur][4*BITS +: PIW]);
      if (m_ph == 4) done_cycles++;
      s_se = scan_en; s_cap = cap_en; s_si = scan_in;
      case (m_ph)
        0: if (pat_rd_ready) begin
             m_cur = m_idx; m_load = 1; m_ph = 1; m_cnt = 0;
           end
        1: begin
             if (m_unl) begin
               for (int c = 0; c < NC; c++) begin
                 if (m_cnt < clen(c) && mem[m_prev][3*BITS+c*ML+m_cnt] &&
                     so_bits[c] !== mem[m_prev][2*BITS+c*ML+m_cnt]) m_fail = 1;
               end
             end
             m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
             if (m_cnt == ML - 1) begin
               m_unl = 0;
               m_ph  = m_load ? 2 : 4;
             end else m_cnt++;
           end
        2: begin
             if (|((po_sample ^ mem[m_cur][4*BITS+PIW +: POW]) & mem[m_cur][4*BITS+PIW+POW +: POW]))
               m_fail = 1;
             m_ph = 3;
           end
        3: begin
             m_prev = m_cur; m_unl = 1; m_load = 0; m_cnt = 0;
             if (m_idx == NPAT - 1) m_ph = 1;
             else begin m_idx++; m_ph = 0; end
           end
        default: ;
      endcase
      @(posedge clk);
      #1;
      for (int c = 0; c < NC; c++) begin
        if (s_se) begin
          for (int i = ML - 1; i > 0; i--) chain[c][i] = chain[c][i-1];
          chain[c][0] = s_si[c];
        end
        if (s_cap) chain[c] = ~chain[c];
      end
      drive_ready(delay);
      cyc++;
    end
    if (cyc >= RUN_LIMIT) check({"watchdog run ", tag}, 1'b0, 1'b1);
    check({"R10 done at end ", tag}, done, 1'b1);
    check({tag, " final fail"}, fail, exp_fail);
  endtask

  initial begin
    run_case(0, 0, 1'b0, "R8 clean overlap no stall");
    run_case(0, 2, 1'b0, "R11 clean with back-pressure");
    run_case(1, 1, 1'b0, "R7 R8 masked bits ignored");
    run_case(2, 0, 1'b1, "R8 unmasked unload mismatch");
    run_case(3, 0, 1'b1, "R7 output mismatch");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule